// File: doc/BRIEF.md
# Byte-Code Fetch-Execute Sequencer

This block runs a small accumulator program straight out of a program ROM. A 16-bit program counter addresses the ROM one byte per clock. A three-phase sequencer first takes the opcode, then takes the data byte when the opcode has one, and then executes the instruction. The supported instructions are:

- load an immediate into the accumulator;
- load an immediate into one of eight working registers;
- add a working register to the accumulator;
- add an immediate to the accumulator;
- a short jump whose signed offset is counted from the address of the following instruction.

Opcodes are the usual one- and two-byte encodings of a classic 8-bit accumulator machine.

The ROM read is combinational. `rom_data` must present the byte at `rom_addr` in the same cycle, and there is no back-pressure on the fetch path. The accumulator is visible on `acc`. Any working register can be read on `reg_val` by setting `reg_sel`. A jump to its own address stops the engine and raises `halted`. An opcode outside the set behaves as a one-byte no-op and latches `illegal`.

Top module: `bytecode_seq`

## Requirements
- R1: While rst_n is low and after its release, rom_addr is 0000h, acc is 00h, all registers read 00h, and halted and illegal are low.
- R2: Opcode 74h with a data byte writes that byte into acc; the instruction occupies two bytes.
- R3: Opcode 78h+n (n = opcode bits 2:0) with a data byte writes the byte into register n only; other registers keep their values.
- R4: Opcode 28h+n adds register n to acc modulo 256; the instruction occupies one byte.
- R5: Opcode 24h with a data byte adds that byte to acc modulo 256.
- R6: rom_addr advances by one in each opcode-fetch and operand-fetch cycle and holds in the execute cycle, so a two-byte instruction takes 3 clocks and a one-byte instruction takes 2.
- R7: Opcode 80h with an offset byte sets rom_addr to (address after the offset byte) + sign-extended offset, both forward and backward.
- R8: A jump whose target equals its own opcode address (offset FEh) sets halted, keeps rom_addr at that address, and both stay until reset.
- R9: An opcode outside R2 to R7 consumes one byte, leaves acc and the registers unchanged, and sets illegal, which stays high until reset.
- R10: acc changes only at the end of an execute cycle, never in a fetch cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rom_addr | output | 16 | Program ROM byte address (the program counter) |
| rom_data | input | 8 | ROM byte at rom_addr, valid in the same cycle |
| reg_sel | input | 3 | Selects the working register shown on reg_val |
| acc | output | 8 | Accumulator value |
| reg_val | output | 8 | Value of the register chosen by reg_sel |
| halted | output | 1 | Engine stopped on a self-jump |
| illegal | output | 1 | Sticky flag: an unsupported opcode was seen |

## Verification
The main sweep tries every register index with eight different triples of operands. Each program loads the accumulator, loads register n, adds register n and adds an immediate. The triples include sums that wrap past FFh, and reading a neighbouring register shows that a write lands on the selected index only.

A fixed program checks the cycle at which rom_addr reaches each instruction boundary and that acc does not move during fetch cycles. Separate programs cover these cases:

- a forward jump, which shows that the skipped loads have no effect;
- a backward jump with a negative offset;
- an unsupported opcode, which shows that it consumes exactly one byte.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [1:0] {ST_OPC, ST_ARG, ST_EXEC, ST_HALT} seq_state_t;
  typedef enum logic [2:0] {K_MOVA, K_MOVR, K_ADDR, K_ADDI, K_JMP, K_BAD} op_kind_t;

  localparam logic [7:0] OP_MOVA = 8'h74;
  localparam logic [7:0] OP_ADDI = 8'h24;
  localparam logic [7:0] OP_JREL = 8'h80;
  localparam logic [4:0] GRP_MOVR = 5'b01111; // 78h..7Fh
  localparam logic [4:0] GRP_ADDR = 5'b00101; // 28h..2Fh

  function automatic logic op_two_byte(input logic [7:0] o);
    return (o == OP_MOVA) || (o == OP_ADDI) || (o == OP_JREL) || (o[7:3] == GRP_MOVR);
  endfunction
endpackage

// File: rtl/bcs_decode.sv
module bcs_decode
  import bcs_pkg::*;
#(
  parameter int RSEL_W = 3
) (
  input  logic [7:0]        opc,
  output op_kind_t          kind,
  output logic [RSEL_W-1:0] rn
);
  always_comb begin
    rn = opc[RSEL_W-1:0];
    if (opc == OP_MOVA)             kind = K_MOVA;
    else if (opc[7:3] == GRP_MOVR)  kind = K_MOVR;
    else if (opc[7:3] == GRP_ADDR)  kind = K_ADDR;
    else if (opc == OP_ADDI)        kind = K_ADDI;
    else if (opc == OP_JREL)        kind = K_JMP;
    else                            kind = K_BAD;
  end
endmodule

// File: rtl/bcs_regs.sv
module bcs_regs #(
  parameter int NREG   = 8,
  parameter int RSEL_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [RSEL_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [RSEL_W-1:0] raddr_a,
  output logic [7:0]        rdata_a,
  input  logic [RSEL_W-1:0] raddr_b,
  output logic [7:0]        rdata_b
);
  logic [7:0] mem [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/bcs_branch.sv
module bcs_branch #(
  parameter int PC_W = 16
) (
  input  logic [PC_W-1:0] next_pc,
  input  logic [PC_W-1:0] ins_addr,
  input  logic [7:0]      off,
  output logic [PC_W-1:0] target,
  output logic            self_loop
);
  assign target    = next_pc + {{(PC_W-8){off[7]}}, off};
  assign self_loop = (target == ins_addr);
endmodule

// File: rtl/bytecode_seq.sv
module bytecode_seq
  import bcs_pkg::*;
#(
  parameter int PC_W = 16,
  parameter int NREG = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  output logic [PC_W-1:0]         rom_addr,
  input  logic [7:0]              rom_data,
  input  logic [$clog2(NREG)-1:0] reg_sel,
  output logic [7:0]              acc,
  output logic [7:0]              reg_val,
  output logic                    halted,
  output logic                    illegal
);
  localparam int RSEL_W = $clog2(NREG);

  seq_state_t        state;
  logic [PC_W-1:0]   pc, ins_addr, target;
  logic [7:0]        opc, arg, acc_q, rn_val;
  logic              halted_q, illegal_q, self_loop;
  op_kind_t          kind;
  logic [RSEL_W-1:0] rn;
  logic              reg_we;

  bcs_decode #(.RSEL_W(RSEL_W)) u_dec (.opc(opc), .kind(kind), .rn(rn));

  assign reg_we = (state == ST_EXEC) && (kind == K_MOVR);

  bcs_regs #(.NREG(NREG), .RSEL_W(RSEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(rn), .wdata(arg),
    .raddr_a(reg_sel), .rdata_a(reg_val), .raddr_b(rn), .rdata_b(rn_val)
  );

  bcs_branch #(.PC_W(PC_W)) u_br (
    .next_pc(pc), .ins_addr(ins_addr), .off(arg), .target(target), .self_loop(self_loop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_OPC;
      pc        <= '0;
      ins_addr  <= '0;
      opc       <= '0;
      arg       <= '0;
      acc_q     <= '0;
      halted_q  <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      case (state)
        ST_OPC: begin
          opc      <= rom_data;
          ins_addr <= pc;
          pc       <= pc + 1'b1;
          state    <= op_two_byte(rom_data) ? ST_ARG : ST_EXEC;
        end
        ST_ARG: begin
          arg   <= rom_data;
          pc    <= pc + 1'b1;
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          state <= ST_OPC;
          case (kind)
            K_MOVA: acc_q <= arg;
            K_ADDR: acc_q <= acc_q + rn_val;
            K_ADDI: acc_q <= acc_q + arg;
            K_JMP: begin
              pc <= target;
              if (self_loop) begin
                halted_q <= 1'b1;
                state    <= ST_HALT;
              end
            end
            K_BAD:   illegal_q <= 1'b1;
            default: ;
          endcase
        end
        default: state <= ST_HALT;
      endcase
    end
  end

  assign rom_addr = pc;
  assign acc      = acc_q;
  assign halted   = halted_q;
  assign illegal  = illegal_q;
endmodule

// File: rtl/bcs_chk.sv
module bcs_chk
  import bcs_pkg::*;
#(
  parameter int PC_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] rom_addr,
  input logic [7:0]      acc,
  input logic            halted,
  input logic            illegal,
  input seq_state_t      st
);
  // R1
  rst_state_chk: assert property (@(posedge clk)
    !rst_n |=> (rom_addr == '0 && acc == 8'h00 && !halted && !illegal));

  // R6
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OPC || st == ST_ARG) |=> (rom_addr == $past(rom_addr) + 1'b1));

  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(rom_addr));

  // R9
  illegal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> illegal);

  // R10
  acc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_EXEC) |=> $stable(acc));
endmodule

bind bytecode_seq bcs_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .acc(acc),
  .halted(halted), .illegal(illegal), .st(state)
);

// File: tb/tb_bytecode_seq.sv
`timescale 1ns/1ps
module tb_bytecode_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] rom_addr;
  logic [7:0]  rom_data;
  logic [2:0]  reg_sel = '0;
  logic [7:0]  acc, reg_val;
  logic        halted, illegal;
  logic [7:0]  rom [256];
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  assign rom_data = (rom_addr[15:8] == 8'h00) ? rom[rom_addr[7:0]] : 8'h00;

  bytecode_seq dut (
    .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .rom_data(rom_data),
    .reg_sel(reg_sel), .acc(acc), .reg_val(reg_val), .halted(halted), .illegal(illegal)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_reg(input int n, output logic [7:0] v);
    reg_sel = n[2:0];
    #1 v = reg_val;
  endtask

  task automatic clear_rom();
    for (int i = 0; i < 256; i++) rom[i] = 8'h00;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_to_halt();
    rst_n = 1'b1;
    for (int c = 0; c < 400 && !halted; c++) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected halt");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    // Program with known sum: R5=25h, R7=34h, acc=25h+34h+12h, self-loop at 000Ah
    clear_rom();
    {rom[0],rom[1],rom[2],rom[3],rom[4],rom[5]} = {8'h7D,8'h25,8'h7F,8'h34,8'h74,8'h00};
    {rom[6],rom[7],rom[8],rom[9],rom[10],rom[11]} = {8'h2D,8'h2F,8'h24,8'h12,8'h80,8'hFE};
    do_reset();
    chk("R1 addr", rom_addr, 16'h0000);
    chk("R1 acc", {8'h00, acc}, 16'h0000);
    chk("R1 flags", {14'h0, halted, illegal}, 16'h0000);
    for (int n = 0; n < 8; n++) begin
      rd_reg(n, v);
      chk("R1 reg", {8'h00, v}, 16'h0000);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 after 3 clk", rom_addr, 16'h0002);
    repeat (3) @(negedge clk);
    chk("R6 after 6 clk", rom_addr, 16'h0004);
    repeat (3) @(negedge clk);
    chk("R6 after 9 clk", rom_addr, 16'h0006);
    repeat (2) @(negedge clk);
    chk("R6 R4 one-byte after 11 clk", rom_addr, 16'h0007);
    run_to_halt();
    chk("R5 R4 sum", {8'h00, acc}, 16'h006B);
    rd_reg(5, v); chk("R3 R5", {8'h00, v}, 16'h0025);
    rd_reg(7, v); chk("R3 R7", {8'h00, v}, 16'h0034);
    chk("R8 halted", {15'h0, halted}, 16'h0001);
    chk("R8 addr", rom_addr, 16'h000A);
    chk("R9 no illegal", {15'h0, illegal}, 16'h0000);
    repeat (5) @(negedge clk);
    chk("R8 hold", {halted, rom_addr[14:0]}, 16'h800A);

    // R10 / R2: acc quiet during fetch cycles
    clear_rom();
    {rom[0],rom[1],rom[2],rom[3]} = {8'h74,8'h5A,8'h80,8'hFE};
    do_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 acc in fetch", {8'h00, acc}, 16'h0000);
    @(negedge clk);
    chk("R2 acc after exec", {8'h00, acc}, 16'h005A);

    // Sweep: every register index, several operand triples (R2 R3 R4 R5)
    for (int n = 0; n < 8; n++) begin
      for (int k = 0; k < 8; k++) begin
        logic [7:0] a, b, c, e;
        a = 8'(k * 37 + n);
        b = 8'(k * 91 + 3);
        c = 8'(255 - k * 29);
        e = a + b + c;
        clear_rom();
        {rom[0],rom[1],rom[2],rom[3]} = {8'h74, a, 8'(8'h78 + n), b};
        {rom[4],rom[5],rom[6],rom[7],rom[8]} = {8'(8'h28 + n), 8'h24, c, 8'h80, 8'hFE};
        do_reset();
        run_to_halt();
        chk("R4 R5 sweep acc", {8'h00, acc}, {8'h00, e});
        rd_reg(n, v);
        chk("R3 sweep reg", {8'h00, v}, {8'h00, b});
        rd_reg((n + 1) % 8, v);
        chk("R3 other reg", {8'h00, v}, 16'h0000);
        chk("R8 sweep addr", rom_addr, 16'h0007);
      end
    end

    // R7 forward jump skips a load
    clear_rom();
    {rom[0],rom[1],rom[2],rom[3]} = {8'h80,8'h02,8'h74,8'h11};
    {rom[4],rom[5],rom[6],rom[7]} = {8'h74,8'h22,8'h80,8'hFE};
    do_reset();
    run_to_halt();
    chk("R7 forward acc", {8'h00, acc}, 16'h0022);
    chk("R7 forward halt addr", rom_addr, 16'h0006);

    // R7 backward jump (offset FAh from 0008h to 0002h)
    clear_rom();
    {rom[0],rom[1],rom[2],rom[3]} = {8'h80,8'h04,8'h74,8'h33};
    {rom[4],rom[5],rom[6],rom[7]} = {8'h80,8'hFE,8'h80,8'hFA};
    do_reset();
    run_to_halt();
    chk("R7 backward acc", {8'h00, acc}, 16'h0033);
    chk("R7 backward halt addr", rom_addr, 16'h0004);

    // R9 unsupported opcode A5h is a one-byte no-op
    clear_rom();
    {rom[0],rom[1],rom[2],rom[3],rom[4],rom[5]} = {8'h74,8'h44,8'hA5,8'h80,8'hFE,8'h00};
    do_reset();
    run_to_halt();
    chk("R9 acc kept", {8'h00, acc}, 16'h0044);
    chk("R9 illegal set", {15'h0, illegal}, 16'h0001);
    chk("R9 one byte consumed", rom_addr, 16'h0003);
    for (int n = 0; n < 8; n++) begin
      rd_reg(n, v);
      chk("R9 regs kept", {8'h00, v}, 16'h0000);
    end
    repeat (3) @(negedge clk);
    chk("R9 sticky", {15'h0, illegal}, 16'h0001);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule